// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block decides, for every vertical period and for every horizontal line in it, whether the image sensor's substrate-discharge (SUB) pulse is enabled. It follows two one-cycle strobes: one that opens a new vertical period (field) and one that opens a new horizontal line. Four committed shutter fields steer it: a 2-bit shutter mode, a vertical-period count, a horizontal-line count and a burst-period selector. A pulse shaper further down the chip uses the per-line enable to place the actual SUB waveform inside a line. That shaping is not part of this block.

An exposure starts at a vertical strobe. At that strobe the block copies the shutter inputs into its own registers. A short exposure fits inside one field. A long exposure spans several fields. During a long exposure, a busy flag stays high and the upstream serial loader must hold off. The shutter inputs are not sampled again until the last field of the exposure has begun. A separate mode does not discharge the substrate at all, and it flags that the next readout must be suppressed. This lets exposure run on through a further field.

Lines of a field are numbered 0 to LINES-1. Line 0 is the line opened by the vertical strobe and is the readout line. A SUB burst therefore occupies the last lines of a field, just before the next readout.

Top module: `shutter_seq_top`

## Requirements
- R1: While reset is low, and on the first cycle after it, sub_en_o, busy_o and readout_stop_o are all 0. A reset during a long exposure abandons that exposure.
- R2: When shutter mode 2'b00 (stopped) is committed, sub_en_o stays 0 on every line. The count fields have no effect, and busy_o stays 0.
- R3: When mode 2'b01 is committed with vertical count 0, the exposure lasts one field, and the shutter inputs are committed again at every vertical strobe. sub_en_o is 1 exactly on lines with index ≥ LINES-1-shd, which is shd+1 lines ending at line LINES-1.
- R4: When the committed line count shd is ≥ LINES-1, sub_en_o is 1 on every line of the burst period, line 0 included.
- R5: When mode 2'b01 is committed with vertical count svd ≥ 1, the exposure spans svd+1 fields. These are numbered 0 to svd from the committing strobe. busy_o is 1 in fields 0 to svd-1 and 0 in field svd.
- R6: While busy_o is 1, changes on mode_i, svd_i, shd_i and spl_i, and further vertical strobes, leave the committed fields unchanged. The burst pattern of the running exposure is unaffected.
- R7: The burst is emitted only in field number spl of the exposure. If spl > svd, no field carries a burst.
- R8: When mode 2'b10 or 2'b11 (readout stop) is committed, readout_stop_o is 1 for that field, sub_en_o stays 0, and busy_o stays 0, whatever the count fields hold.
- R9: A vertical strobe has priority over a horizontal strobe in the same cycle: the line index becomes 0. A horizontal strobe on line LINES-1 leaves the index at LINES-1.
- R10: Shutter inputs are committed only at a vertical strobe. A change between strobes has no effect on sub_en_o until the next vertical strobe that ends the exposure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | One-cycle strobe opening a vertical period |
| hsync_i | input | 1 | One-cycle strobe opening the next line |
| mode_i | input | 2 | Shutter mode: 00 stopped, 01 variable speed, 1x readout stop |
| svd_i | input | SVD_W | Extra vertical periods of the exposure |
| shd_i | input | SHD_W | SUB line count minus one |
| spl_i | input | SVD_W | Field of the exposure that carries the burst |
| sub_en_o | output | 1 | SUB enabled for the current line |
| readout_stop_o | output | 1 | Suppress the readout pulses of this field |
| busy_o | output | 1 | Long exposure in progress; hold off new shutter data |

## Verification
A wrong field counter shows up at the ports as a burst in the wrong field or as busy_o dropping one field early or late. Either is visible within one vertical period of the error. A wrong line index or a wrong tail boundary moves the first enabled line. It therefore appears on the very line where it happens. A commit that happens while busy, or between strobes, replaces the burst pattern from the next line onward, so it is caught within that field.

// File: rtl/ss_pkg.sv
// Shared types for the shutter sequencer.
package ss_pkg;
    typedef enum logic [1:0] {
        SM_STOP  = 2'b00,   // no substrate discharge
        SM_VAR   = 2'b01,   // high/low speed exposure
        SM_HOLD  = 2'b10,   // readout stop
        SM_HOLD2 = 2'b11    // readout stop (alias)
    } shut_mode_e;
endpackage

// File: rtl/ss_line_ctr.sv
// Line index within the current field.
// Assumes strobes are one cycle wide; vertical strobe wins over horizontal.
module ss_line_ctr #(
    parameter int LINES  = 525,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              hsync_i,
    output logic [LINE_W-1:0] line_idx_o
);
    localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(LINES - 1);

    // Restart at a field start, advance per line, hold at the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_idx_o <= '0;
        else if (vsync_i)
            line_idx_o <= '0;
        else if (hsync_i && line_idx_o != LAST_IDX)
            line_idx_o <= line_idx_o + 1'b1;
    end
endmodule

// File: rtl/ss_exposure.sv
// Commits shutter fields at the field that opens an exposure and counts
// fields within it. Assumes svd only matters in variable-speed mode.
module ss_exposure
    import ss_pkg::*;
#(
    parameter int SVD_W = 8,
    parameter int SHD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic [1:0]       mode_i,
    input  logic [SVD_W-1:0] svd_i,
    input  logic [SHD_W-1:0] shd_i,
    input  logic [SVD_W-1:0] spl_i,
    output shut_mode_e       act_mode_o,
    output logic [SVD_W-1:0] act_svd_o,
    output logic [SHD_W-1:0] act_shd_o,
    output logic [SVD_W-1:0] act_spl_o,
    output logic [SVD_W-1:0] per_cnt_o,
    output logic             busy_o
);
    logic [SVD_W-1:0] eff_svd;
    logic             last_field;

    // Field count of the running exposure; only variable mode spans fields.
    always_comb begin
        eff_svd    = (act_mode_o == SM_VAR) ? act_svd_o : '0;
        last_field = (per_cnt_o == eff_svd);
        busy_o     = !last_field;
    end

    // Commit at the strobe that ends the exposure, otherwise step the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode_o <= SM_STOP;
            act_svd_o  <= '0;
            act_shd_o  <= '0;
            act_spl_o  <= '0;
            per_cnt_o  <= '0;
        end else if (vsync_i) begin
            if (last_field) begin
                act_mode_o <= shut_mode_e'(mode_i);
                act_svd_o  <= svd_i;
                act_shd_o  <= shd_i;
                act_spl_o  <= spl_i;
                per_cnt_o  <= '0;
            end else begin
                per_cnt_o  <= per_cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_sub_gate.sv
// Decides the per-line SUB enable from committed state.
// Assumes the burst ends on the last line before readout (line 0).
module ss_sub_gate
    import ss_pkg::*;
#(
    parameter int LINES  = 525,
    parameter int LINE_W = $clog2(LINES),
    parameter int SVD_W  = 8,
    parameter int SHD_W  = 10
) (
    input  shut_mode_e        act_mode_i,
    input  logic [SHD_W-1:0]  act_shd_i,
    input  logic [SVD_W-1:0]  act_spl_i,
    input  logic [SVD_W-1:0]  per_cnt_i,
    input  logic [LINE_W-1:0] line_idx_i,
    output logic              sub_en_o,
    output logic              readout_stop_o
);
    localparam logic [31:0] LAST = 32'(LINES - 1);

    logic [31:0] shd_ext;
    logic [31:0] first_line;
    logic        in_tail;
    logic        in_burst_field;

    // First enabled line of the tail window, saturating at line 0.
    always_comb begin
        shd_ext        = 32'(act_shd_i);
        first_line     = (shd_ext >= LAST) ? 32'd0 : (LAST - shd_ext);
        in_tail        = (32'(line_idx_i) >= first_line);
        in_burst_field = (per_cnt_i == act_spl_i);
        sub_en_o       = (act_mode_i == SM_VAR) && in_burst_field && in_tail;
        readout_stop_o = (act_mode_i == SM_HOLD) || (act_mode_i == SM_HOLD2);
    end
endmodule

// File: rtl/shutter_seq_top.sv
// Electronic shutter sequencer: per-line SUB enable, readout-stop flag and
// busy flag for long exposures. Assumes one-cycle sync strobes.
module shutter_seq_top
    import ss_pkg::*;
#(
    parameter int SVD_W = 8,
    parameter int SHD_W = 10,
    parameter int LINES = 525,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             hsync_i,
    input  logic [1:0]       mode_i,
    input  logic [SVD_W-1:0] svd_i,
    input  logic [SHD_W-1:0] shd_i,
    input  logic [SVD_W-1:0] spl_i,
    output logic             sub_en_o,
    output logic             readout_stop_o,
    output logic             busy_o
);
    shut_mode_e        act_mode;
    logic [SVD_W-1:0]  act_svd;
    logic [SHD_W-1:0]  act_shd;
    logic [SVD_W-1:0]  act_spl;
    logic [SVD_W-1:0]  per_cnt;
    logic [LINE_W-1:0] line_idx;

    ss_line_ctr #(.LINES(LINES), .LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
        .line_idx_o(line_idx)
    );

    ss_exposure #(.SVD_W(SVD_W), .SHD_W(SHD_W)) u_expo (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i),
        .mode_i(mode_i), .svd_i(svd_i), .shd_i(shd_i), .spl_i(spl_i),
        .act_mode_o(act_mode), .act_svd_o(act_svd), .act_shd_o(act_shd),
        .act_spl_o(act_spl), .per_cnt_o(per_cnt), .busy_o(busy_o)
    );

    ss_sub_gate #(.LINES(LINES), .LINE_W(LINE_W), .SVD_W(SVD_W), .SHD_W(SHD_W)) u_gate (
        .act_mode_i(act_mode), .act_shd_i(act_shd), .act_spl_i(act_spl),
        .per_cnt_i(per_cnt), .line_idx_i(line_idx),
        .sub_en_o(sub_en_o), .readout_stop_o(readout_stop_o)
    );
endmodule

// File: rtl/ss_seq_checker.sv
// Property checker for shutter_seq_top, attached by bind below.
module ss_seq_checker #(
    parameter int SVD_W  = 8,
    parameter int SHD_W  = 10,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_i,
    input logic              hsync_i,
    input logic              sub_en_o,
    input logic              readout_stop_o,
    input logic              busy_o,
    input logic [1:0]        act_mode,
    input logic [SVD_W-1:0]  act_svd,
    input logic [SHD_W-1:0]  act_shd,
    input logic [SVD_W-1:0]  act_spl,
    input logic [SVD_W-1:0]  per_cnt,
    input logic [LINE_W-1:0] line_idx
);
    assert_stopped_no_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 2'b00) |-> !sub_en_o);

    assert_busy_moves_at_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> $stable(busy_o));

    assert_field_within_exposure_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 2'b01) |-> (per_cnt <= act_svd));

    assert_fields_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable({act_mode, act_svd, act_shd, act_spl}));

    assert_hold_no_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
        readout_stop_o |-> (!sub_en_o && !busy_o));

    assert_line_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (line_idx == '0));

    assert_sub_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_i && !hsync_i) |=> $stable(sub_en_o));
endmodule

bind shutter_seq_top ss_seq_checker #(.SVD_W(SVD_W), .SHD_W(SHD_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
    .sub_en_o(sub_en_o), .readout_stop_o(readout_stop_o), .busy_o(busy_o),
    .act_mode(act_mode), .act_svd(act_svd), .act_shd(act_shd), .act_spl(act_spl),
    .per_cnt(per_cnt), .line_idx(line_idx)
);

// File: tb/tb_shutter_seq_top.sv
`timescale 1ns/1ps
module tb_shutter_seq_top;
    localparam int LINES = 6;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  svd;
        logic [9:0]  shd;
        logic [7:0]  spl;
        logic [2:0]  nf;     // fields checked
        logic [3:0]  busy;   // expected busy per field
        logic [23:0] masks;  // 6-bit line mask per field
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 8'd0, 10'd0, 8'd0, 3'd1, 4'b0000, 24'h000020}, // R3 one line
        '{2'b01, 8'd0, 10'd2, 8'd0, 3'd1, 4'b0000, 24'h000038}, // R3 three lines
        '{2'b01, 8'd0, 10'd4, 8'd0, 3'd1, 4'b0000, 24'h00003E}, // R4 edge below
        '{2'b01, 8'd0, 10'd9, 8'd0, 3'd1, 4'b0000, 24'h00003F}, // R4 saturate
        '{2'b00, 8'd5, 10'd3, 8'd0, 3'd1, 4'b0000, 24'h000000}, // R2
        '{2'b01, 8'd2, 10'd1, 8'd1, 3'd3, 4'b0011, 24'h000C00}, // R5 R6 R7
        '{2'b01, 8'd1, 10'd0, 8'd3, 3'd2, 4'b0001, 24'h000000}, // R7 out of range
        '{2'b01, 8'd3, 10'd5, 8'd0, 3'd4, 4'b0111, 24'h00003F}, // R5 R6
        '{2'b10, 8'd2, 10'd2, 8'd0, 3'd1, 4'b0000, 24'h000000}, // R8
        '{2'b11, 8'd1, 10'd5, 8'd0, 3'd1, 4'b0000, 24'h000000}  // R8 alias
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vsync_i, hsync_i;
    logic [1:0] mode_i;
    logic [7:0] svd_i, spl_i;
    logic [9:0] shd_i;
    logic       sub_en_o, readout_stop_o, busy_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shutter_seq_top #(.SVD_W(8), .SHD_W(10), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
        .mode_i(mode_i), .svd_i(svd_i), .shd_i(shd_i), .spl_i(spl_i),
        .sub_en_o(sub_en_o), .readout_stop_o(readout_stop_o), .busy_o(busy_o)
    );

    function automatic string tag_of(int e);
        case (e)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R2";
            5:       return "R5/R6/R7";
            6:       return "R7";
            7:       return "R5/R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic strobe(logic v, logic h);
        @(negedge clk);
        vsync_i = v; hsync_i = h;
        @(negedge clk);
        vsync_i = 1'b0; hsync_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; vsync_i = 1'b0; hsync_i = 1'b0;
        mode_i = 2'b00; svd_i = '0; shd_i = '0; spl_i = '0;
        repeat (3) @(negedge clk);
        check("R1", "sub in reset", int'(sub_en_o), 0);
        check("R1", "busy in reset", int'(busy_o), 0);
        check("R1", "hold in reset", int'(readout_stop_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy_o), 0);

        // Table walk: commit, then present conflicting data during the exposure.
        for (int e = 0; e < NV; e++) begin
            mode_i = VECS[e].mode; svd_i = VECS[e].svd;
            shd_i  = VECS[e].shd;  spl_i = VECS[e].spl;
            strobe(1'b1, 1'b0);
            mode_i = 2'b01; svd_i = 8'd0; shd_i = 10'd5; spl_i = 8'd0;
            for (int f = 0; f < int'(VECS[e].nf); f++) begin
                if (f > 0) strobe(1'b1, 1'b0);
                check(tag_of(e), $sformatf("hold e%0d f%0d", e, f),
                      int'(readout_stop_o), int'(VECS[e].mode[1]));
                for (int l = 0; l < LINES; l++) begin
                    check(tag_of(e), $sformatf("sub e%0d f%0d l%0d", e, f, l),
                          int'(sub_en_o), int'(VECS[e].masks[f*6 + l]));
                    check(tag_of(e), $sformatf("busy e%0d f%0d l%0d", e, f, l),
                          int'(busy_o), int'(VECS[e].busy[f]));
                    if (l < LINES - 1) strobe(1'b0, 1'b1);
                end
            end
        end

        // R9: simultaneous strobes restart the line; hsync saturates at the end.
        mode_i = 2'b01; svd_i = 8'd0; shd_i = 10'd0; spl_i = 8'd0;
        strobe(1'b1, 1'b0);
        for (int k = 0; k < LINES + 1; k++) strobe(1'b0, 1'b1);
        check("R9", "sub held on last line", int'(sub_en_o), 1);
        strobe(1'b1, 1'b1);
        check("R9", "sub after joint strobe", int'(sub_en_o), 0);

        // R10: mid-field input change waits for the next vertical strobe.
        shd_i = 10'd5;
        strobe(1'b0, 1'b1);
        check("R10", "sub before commit", int'(sub_en_o), 0);
        strobe(1'b1, 1'b0);
        check("R10", "sub after commit", int'(sub_en_o), 1);

        // R1: reset abandons a long exposure.
        svd_i = 8'd3; shd_i = 10'd0;
        strobe(1'b1, 1'b0);
        check("R5", "busy long exposure", int'(busy_o), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", "busy after mid reset", int'(busy_o), 0);
        check("R1", "sub after mid reset", int'(sub_en_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule